// File: doc/BRIEF.md
# Video Raster Timing and Vertical-Blank Interrupt Generator

This block keeps the beam position for a display frame: a dot counter that steps once per clock along a line, a line counter that steps when a line ends, and a frame counter that steps when the last line ends. From the line position it keeps a vertical-blank flag. When that flag goes high and interrupts are enabled, it sends the processor a non-maskable interrupt request that lasts one clock.

The processor reaches the block through a small register port with a two-bit address. Address 0 is the write-only interrupt-control register, and bit 7 of a write there is the interrupt enable. Address 1 reads the vertical-blank interrupt status. Address 2 reads a blank-status byte with a vertical-blank bit and a horizontal-blank bit. The horizontal-blank window wraps around the end of the line. Reads are combinational and have no side effects.

Top module: `raster_nmi_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears the dot, line and frame counters, the vertical-blank flag, the interrupt enable and `nmi_req`.
- R2: On each clock the dot counter adds 1. When it holds 340 it goes to 0 instead.
- R3: When the dot counter goes from 340 to 0, the line counter adds 1. If the line counter held 259 it goes to 0 instead, and the frame counter adds 1.
- R4: The vertical-blank flag is set by the edge that takes the line counter to 225 and is cleared by the edge that takes it from 259 to 0. Reading address 1 returns 0x80 while the flag is set and 0x00 while it is clear.
- R5: A write (`cpu_wr` high) to address 0 loads bit 7 of `cpu_wdata` into the interrupt enable at that clock edge. The other data bits are ignored.
- R6: `nmi_req` is high for exactly one clock: the clock in which the line counter is 225 and the dot counter is 0. It rises only if the interrupt enable was 1 before the edge that entered line 225.
- R7: Turning the interrupt enable on while vertical blank is already under way produces no request until the next entry into line 225.
- R8: Reading address 2 gives bit 7 = 1 when the line counter is 225 or more, and bit 6 = 1 when the dot counter is 0x121 or more, or 0x15 or less. Both bits can be 1 at the same time. Bits 5 to 0 read 0.
- R9: Reading address 0 or address 3 returns 0x00. A write to any address other than 0 leaves the interrupt enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Each cycle is one dot. |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select: 0 control, 1 interrupt status, 2 blank status, 3 unused |
| cpu_wdata | input | 8 | Write data. Only bit 7 is used, at address 0. |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| dot_cnt | output | 9 | Dot position in the line |
| line_cnt | output | 9 | Line position in the frame |
| frame_cnt | output | 16 | Count of completed frames |
| nmi_req | output | 1 | Interrupt request pulse, one clock long |

## Verification
The counters, the flag, the enable and `nmi_req` each change at the same clock edge that sees their cause, with one register stage and no pipeline. A write to address 0 therefore takes effect at its own edge, and the interrupt request appears in the cycle whose registered position reads line 225, dot 0. Read data follows `cpu_addr` and the registered position combinationally, in the same cycle. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the inputs it sees there. Every output is compared a quarter period after the falling edge, so each expected value is due in the cycle right after the edge that produced it. The interrupt enable is switched on before the first vertical blank, off before the second, and on again midway through the second, and the bench checks that exactly one pulse occurs, at line 225, dot 0.

// File: rtl/raster_pkg.sv
// Package: shared register-select encoding and status bit positions for the
// raster timing block. Assumes a two-bit register address.
package raster_pkg;

    typedef enum logic [1:0] {
        SEL_IRQ_CTRL   = 2'd0,
        SEL_NMI_STAT   = 2'd1,
        SEL_BLANK_STAT = 2'd2,
        SEL_SPARE      = 2'd3
    } reg_sel_e;

    localparam int STAT_VBL_BIT = 7;
    localparam int STAT_HBL_BIT = 6;
    localparam int CTRL_EN_BIT  = 7;

endpackage

// File: rtl/raster_counter.sv
// raster_counter: dot/line/frame position counters. The dot counter steps
// every clock and wraps after DOT_LAST. The line counter steps on a dot wrap
// and wraps after LINE_WRAP-1, and the frame counter then steps. The module
// also flags the cycles whose edge enters or leaves vertical blank.
// Assumes LINE_VBL < LINE_WRAP and synchronous active-low reset.
module raster_counter #(
    parameter int DOT_LAST  = 340,
    parameter int LINE_VBL  = 225,
    parameter int LINE_WRAP = 260,
    parameter int DOT_W     = 9,
    parameter int LINE_W    = 9,
    parameter int FRAME_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [DOT_W-1:0]   dot,
    output logic [LINE_W-1:0]  line,
    output logic [FRAME_W-1:0] frame,
    output logic               vbl_enter,
    output logic               vbl_leave
);

    localparam logic [DOT_W-1:0]  DOT_END   = DOT_W'(DOT_LAST);
    localparam logic [LINE_W-1:0] LINE_END  = LINE_W'(LINE_WRAP - 1);
    localparam logic [LINE_W-1:0] LINE_PRE  = LINE_W'(LINE_VBL - 1);

    logic at_eol;

    // Purpose: detect the last dot of a line.
    always_comb begin
        at_eol = (dot == DOT_END);
    end

    // Purpose: flag the edges that enter and leave vertical blank.
    always_comb begin
        vbl_enter = at_eol && (line == LINE_PRE);
        vbl_leave = at_eol && (line == LINE_END);
    end

    // Purpose: advance the dot, line and frame position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot   <= '0;
            line  <= '0;
            frame <= '0;
        end else if (at_eol) begin
            dot <= '0;
            if (line == LINE_END) begin
                line  <= '0;
                frame <= frame + FRAME_W'(1);
            end else begin
                line <= line + LINE_W'(1);
            end
        end else begin
            dot <= dot + DOT_W'(1);
        end
    end

endmodule

// File: rtl/nmi_ctrl.sv
// nmi_ctrl: holds the vertical-blank flag and the interrupt enable, and emits
// a single-clock request when vertical blank begins with the enable set.
// Assumes vbl_enter and vbl_leave are each high for one clock per frame.
module nmi_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic vbl_enter,
    input  logic vbl_leave,
    input  logic en_wr,
    input  logic en_bit,
    output logic flag,
    output logic enable,
    output logic req
);

    // Purpose: set the flag on vertical-blank entry and clear it on frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (vbl_leave) begin
            flag <= 1'b0;
        end else if (vbl_enter) begin
            flag <= 1'b1;
        end
    end

    // Purpose: load the interrupt enable from processor writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (en_wr) begin
            enable <= en_bit;
        end
    end

    // Purpose: issue a one-clock request on entry, gated by the prior enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else begin
            req <= vbl_enter && enable;
        end
    end

endmodule

// File: rtl/status_mux.sv
// status_mux: builds the readable status bytes from the flag and the beam
// position and selects one by register address. Purely combinational.
// Assumes HB_END < HB_START so the horizontal window wraps the line end.
module status_mux #(
    parameter int LINE_VBL = 225,
    parameter int HB_START = 'h121,
    parameter int HB_END   = 'h15,
    parameter int DOT_W    = 9,
    parameter int LINE_W   = 9
) (
    input  logic [1:0]        sel,
    input  logic              flag,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output logic [7:0]        rdata
);
    import raster_pkg::*;

    localparam logic [LINE_W-1:0] VBL_LINE = LINE_W'(LINE_VBL);
    localparam logic [DOT_W-1:0]  HB_LO    = DOT_W'(HB_START);
    localparam logic [DOT_W-1:0]  HB_HI    = DOT_W'(HB_END);

    logic       in_vbl;
    logic       in_hbl;
    logic [7:0] nmi_byte;
    logic [7:0] blank_byte;

    // Purpose: decode the blank windows from the beam position.
    always_comb begin
        in_vbl = (line >= VBL_LINE);
        in_hbl = (dot >= HB_LO) || (dot <= HB_HI);
    end

    // Purpose: assemble the two status bytes, unused bits zero.
    always_comb begin
        nmi_byte                 = '0;
        nmi_byte[STAT_VBL_BIT]   = flag;
        blank_byte               = '0;
        blank_byte[STAT_VBL_BIT] = in_vbl;
        blank_byte[STAT_HBL_BIT] = in_hbl;
    end

    // Purpose: select the read byte by register address.
    always_comb begin
        case (reg_sel_e'(sel))
            SEL_NMI_STAT:   rdata = nmi_byte;
            SEL_BLANK_STAT: rdata = blank_byte;
            default:        rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/raster_nmi_gen.sv
// raster_nmi_gen: top of the raster timing and vertical-blank interrupt
// block. Joins the position counters, the interrupt controller and the status
// read mux, and decodes processor writes to the control register.
// Assumes one dot per clock and a synchronous active-low reset.
module raster_nmi_gen #(
    parameter int DOT_LAST  = 340,
    parameter int LINE_VBL  = 225,
    parameter int LINE_WRAP = 260,
    parameter int HB_START  = 'h121,
    parameter int HB_END    = 'h15,
    parameter int FRAME_W   = 16,
    parameter int DOT_W     = $clog2(DOT_LAST + 1),
    parameter int LINE_W    = $clog2(LINE_WRAP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [1:0]         cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    output logic [DOT_W-1:0]   dot_cnt,
    output logic [LINE_W-1:0]  line_cnt,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               nmi_req
);
    import raster_pkg::*;

    logic vbl_enter;
    logic vbl_leave;
    logic ctrl_wr;
    logic nmi_flag;
    logic nmi_enable;
    logic unused_wdata;

    // Purpose: decode writes to the interrupt-control register.
    always_comb begin
        ctrl_wr = cpu_wr && (reg_sel_e'(cpu_addr) == SEL_IRQ_CTRL);
    end

    assign unused_wdata = ^cpu_wdata[6:0];

    raster_counter #(
        .DOT_LAST (DOT_LAST),
        .LINE_VBL (LINE_VBL),
        .LINE_WRAP(LINE_WRAP),
        .DOT_W    (DOT_W),
        .LINE_W   (LINE_W),
        .FRAME_W  (FRAME_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot      (dot_cnt),
        .line     (line_cnt),
        .frame    (frame_cnt),
        .vbl_enter(vbl_enter),
        .vbl_leave(vbl_leave)
    );

    nmi_ctrl u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .vbl_enter(vbl_enter),
        .vbl_leave(vbl_leave),
        .en_wr    (ctrl_wr),
        .en_bit   (cpu_wdata[CTRL_EN_BIT]),
        .flag     (nmi_flag),
        .enable   (nmi_enable),
        .req      (nmi_req)
    );

    status_mux #(
        .LINE_VBL(LINE_VBL),
        .HB_START(HB_START),
        .HB_END  (HB_END),
        .DOT_W   (DOT_W),
        .LINE_W  (LINE_W)
    ) u_stat (
        .sel  (cpu_addr),
        .flag (nmi_flag),
        .dot  (dot_cnt),
        .line (line_cnt),
        .rdata(cpu_rdata)
    );

endmodule

// File: rtl/raster_nmi_chk.sv
// raster_nmi_chk: temporal properties of raster_nmi_gen, bound to the top.
module raster_nmi_chk #(
    parameter int DOT_LAST  = 340,
    parameter int LINE_VBL  = 225,
    parameter int LINE_WRAP = 260,
    parameter int FRAME_W   = 16,
    parameter int DOT_W     = 9,
    parameter int LINE_W    = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_wr,
    input logic [1:0]         cpu_addr,
    input logic [7:0]         cpu_wdata,
    input logic [DOT_W-1:0]   dot_cnt,
    input logic [LINE_W-1:0]  line_cnt,
    input logic [FRAME_W-1:0] frame_cnt,
    input logic               nmi_req,
    input logic               nmi_flag,
    input logic               nmi_enable
);
    localparam logic [DOT_W-1:0]  D_END = DOT_W'(DOT_LAST);
    localparam logic [LINE_W-1:0] L_END = LINE_W'(LINE_WRAP - 1);
    localparam logic [LINE_W-1:0] L_VBL = LINE_W'(LINE_VBL);

    // R2
    a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_cnt == D_END) |=> (dot_cnt == '0));
    a_r2_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_cnt != D_END) |=> (dot_cnt == $past(dot_cnt) + DOT_W'(1)));
    // R3
    a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_cnt == D_END && line_cnt == L_END) |=>
        (line_cnt == '0 && frame_cnt == $past(frame_cnt) + FRAME_W'(1)));
    a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_cnt != D_END) |=> $stable(line_cnt));
    // R4
    a_r4_flag_on_vbl: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == L_VBL && dot_cnt == '0) |-> nmi_flag);
    a_r4_flag_off_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt == '0) |-> !nmi_flag);
    // R5
    a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 2'd0) |=> (nmi_enable == $past(cpu_wdata[7])));
    // R9
    a_r9_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == 2'd0) |=> $stable(nmi_enable));
    // R6
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);
    a_r6_pulse_pos: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (line_cnt == L_VBL && dot_cnt == '0));
    // R7
    a_r7_no_late: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $rose(nmi_flag));

endmodule

bind raster_nmi_gen raster_nmi_chk #(
    .DOT_LAST (DOT_LAST),
    .LINE_VBL (LINE_VBL),
    .LINE_WRAP(LINE_WRAP),
    .FRAME_W  (FRAME_W),
    .DOT_W    (DOT_W),
    .LINE_W   (LINE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .dot_cnt   (dot_cnt),
    .line_cnt  (line_cnt),
    .frame_cnt (frame_cnt),
    .nmi_req   (nmi_req),
    .nmi_flag  (nmi_flag),
    .nmi_enable(nmi_enable)
);

// File: tb/sim_raster_nmi_gen.sv
// sim_raster_nmi_gen: behavioural reference model compared every clock.
module sim_raster_nmi_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [8:0]  dot_cnt;
    logic [8:0]  line_cnt;
    logic [15:0] frame_cnt;
    logic        nmi_req;

    int n_run = 0;
    int n_fail = 0;
    int m_dot = 0, m_line = 0, m_frame = 0;
    bit m_flag = 0, m_en = 0, m_req = 0;
    int pulses = 0;
    int pulse_frame = -1;
    bit finished = 0;
    int rot = 0;

    always #10 clk = ~clk;

    raster_nmi_gen u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dot_cnt(dot_cnt),
        .line_cnt(line_cnt), .frame_cnt(frame_cnt), .nmi_req(nmi_req)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (line %0d dot %0d)",
                     tag, act, exp, m_line, m_dot);
        end
    endtask

    // Reference model: advances on the rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dot = 0; m_line = 0; m_frame = 0;
            m_flag = 0; m_en = 0; m_req = 0;
        end else begin
            m_req = 0;
            if (m_dot == 340) begin
                m_dot = 0;
                m_line = m_line + 1;
                if (m_line == 225) begin
                    m_flag = 1;
                    m_req = m_en;
                end
                if (m_line == 260) begin
                    m_line = 0;
                    m_flag = 0;
                    m_frame = m_frame + 1;
                end
            end else begin
                m_dot = m_dot + 1;
            end
            if (cpu_wr && cpu_addr == 2'd0) m_en = cpu_wdata[7];
        end
    end

    function automatic int exp_rdata(input int a);
        int v;
        v = 0;
        if (a == 1) v = m_flag ? 'h80 : 0;
        if (a == 2) begin
            if (m_line >= 225) v = v | 'h80;
            if (m_dot >= 'h121 || m_dot <= 'h15) v = v | 'h40;
        end
        return v;
    endfunction

    // Comparison a quarter period after each falling edge.
    always @(negedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk(dot_cnt == m_dot, "R2 dot", dot_cnt, m_dot);
            chk(line_cnt == m_line, "R3 line", line_cnt, m_line);
            chk(frame_cnt == m_frame, "R3 frame", frame_cnt, m_frame);
            chk(nmi_req == m_req, "R5 R6 nmi_req", nmi_req, m_req);
            if (cpu_addr == 2'd1)
                chk(cpu_rdata == exp_rdata(1), "R4 nmi status", cpu_rdata, exp_rdata(1));
            else if (cpu_addr == 2'd2)
                chk(cpu_rdata == exp_rdata(2), "R8 blank status", cpu_rdata, exp_rdata(2));
            else
                chk(cpu_rdata == 0, "R9 spare read", cpu_rdata, 0);
            if (nmi_req) begin
                pulses++;
                if (pulse_frame < 0) pulse_frame = m_frame;
                chk(line_cnt == 225 && dot_cnt == 0, "R6 pulse position",
                    {line_cnt, dot_cnt}, {9'd225, 9'd0});
            end
        end
    end

    task automatic step();
        @(negedge clk);
        cpu_wr = 1'b0;
        cpu_wdata = 8'h00;
        cpu_addr = 2'(rot);
        rot = (rot + 1) % 4;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_addr = a;
        cpu_wdata = d;
    endtask

    task automatic wait_pos(input int f, input int l);
        while (!(m_frame == f && m_line == l)) step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R1 reset state
        chk(dot_cnt == 0, "R1 dot", dot_cnt, 0);
        chk(line_cnt == 0, "R1 line", line_cnt, 0);
        chk(frame_cnt == 0, "R1 frame", frame_cnt, 0);
        chk(nmi_req == 0, "R1 nmi_req", nmi_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_pos(0, 10);
        wr_reg(2'd0, 8'h80);              // R5 enable before first blank
        wait_pos(1, 100);
        wr_reg(2'd0, 8'h7F);              // R5 disable, low bits ignored
        wait_pos(1, 120);
        wr_reg(2'd3, 8'h80);              // R9 write elsewhere, enable stays 0
        wait_pos(1, 230);
        wr_reg(2'd0, 8'h80);              // R7 enable midway through blank
        wait_pos(2, 5);
        step();
        finished = 1;
        chk(pulses == 1, "R7 pulse count", pulses, 1);
        chk(pulse_frame == 0, "R6 pulse frame", pulse_frame, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule